// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flags

This block is the combinational arithmetic and logic unit of a small 8-bit processor datapath. Each evaluation performs exactly one operation, chosen by a 4-bit code. The operands are the accumulator byte and a second operand byte. The current zero (Z), subtract (N), half-carry (H) and carry (C) flags are also inputs. The block returns a result byte, a strobe that says whether the accumulator or destination should take that byte, and the four next flag values. The flags are also returned packed into one byte, laid out the way a flag register is pushed to the stack.

The surrounding sequencer owns register selection, memory access and cycle timing. It places the operand on `opnd_i`, presents the code, and commits `res_o` and the flags in the same cycle. The operations group into four classes:

- **Arithmetic:** add, add with carry, subtract, subtract with borrow, compare, increment, decrement.
- **Bitwise:** AND, OR, XOR, complement accumulator.
- **Flag-oriented:** set carry, complement carry, decimal adjust.
- **Reserved codes:** these do nothing.

Within these classes, each operation has its own rule for the flags.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) write `acc_i + opnd_i` (+C for code 1) modulo 256 with the write strobe high. Z is set when the result is zero, N is 0, H is the carry out of bit 3 and C is the carry out of bit 7.
- R2: Codes 2 (subtract) and 3 (subtract with borrow) write `acc_i - opnd_i` (-C for code 3) modulo 256 with the write strobe high. N is 1. H is set on a borrow out of the low nibble. C is set when the subtrahend (plus C for code 3) exceeds `acc_i`. Z is set on a zero result.
- R3: Code 4 (compare) gives the same flags as code 2 but holds the write strobe low, and `res_o` equals `acc_i`.
- R4: Codes 5 (AND), 6 (OR) and 7 (XOR) write the bitwise result with N=0 and C=0. H is 1 for AND and 0 for OR and XOR. Z comes from the result.
- R5: Codes 8 (increment) and 9 (decrement) write `opnd_i` plus or minus one and keep C. Increment clears N and sets H on a carry from bit 3. Decrement sets N and sets H when the operand's low nibble is 0. Z comes from the result.
- R6: Code 10 writes `~acc_i`, sets N and H, and keeps Z and C.
- R7: Code 11 forces C=1 and code 12 inverts C. Both clear N and H, keep Z, hold the write strobe low and return `acc_i`.
- R8: Code 13 (decimal adjust) writes the accumulator corrected by 0x06 and/or 0x60.
  - With N=0, 0x60 is added when C=1 or the accumulator exceeds 0x99, and C is then set (otherwise kept). 0x06 is added when H=1 or the low nibble exceeds 9.
  - With N=1, 0x60 is subtracted when C=1 and 0x06 is subtracted when H=1, and C is kept.
  - H is cleared, N is kept and Z comes from the result.
- R9: `flag_byte_o` carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4 of the new flags, and bits 3..0 always read zero.
- R10: Codes 14 and 15 hold the write strobe low, return `acc_i` and pass all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand byte |
| z_i | input | 1 | Current zero flag |
| n_i | input | 1 | Current subtract flag |
| h_i | input | 1 | Current half-carry flag |
| c_i | input | 1 | Current carry flag |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result write strobe |
| z_o | output | 1 | Next zero flag |
| n_o | output | 1 | Next subtract flag |
| h_o | output | 1 | Next half-carry flag |
| c_o | output | 1 | Next carry flag |
| flag_byte_o | output | 8 | Next flags packed into one byte |

## Verification
The bench builds the block at its default 8-bit data width. At that width every pair of accumulator and operand values, with carry in both states, can be applied to each of the sixteen codes. The Z, N and H inputs are taken from operand bits, so every combination of incoming flags also reaches the decimal adjust and the flag-keeping codes. This covers the borrow and nibble-carry corners (0x0F, 0x10, 0xFF, 0x00) and the 0x99 decimal-adjust boundary. It also checks that compare, the carry operations and the reserved codes never raise the write strobe.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW       = 8;
    localparam int NW       = DW / 2;
    localparam int OPW      = 4;
    localparam int NFLAGS   = 4;
    localparam int FLAG_PAD = DW - NFLAGS;

    localparam logic [DW-1:0] DAA_LO_ADJ = 8'h06;
    localparam logic [DW-1:0] DAA_HI_ADJ = 8'h60;
    localparam logic [DW-1:0] BCD_MAX    = 8'h99;
    localparam logic [NW-1:0] DIGIT_MAX  = 4'h9;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_CP    = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_INC   = 4'd8,
        OP_DEC   = 4'd9,
        OP_CPL   = 4'd10,
        OP_SCF   = 4'd11,
        OP_CCF   = 4'd12,
        OP_DAA   = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flags_t        fin,
    output logic [DW-1:0] res,
    output flags_t        fout
);
    logic          cy;
    logic [NW:0]   lo;
    logic [DW:0]   full;
    logic [NW:0]   a_lo, b_lo, cy_lo;
    logic [DW:0]   a_w, b_w, cy_w;

    assign cy    = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
    assign a_lo  = {1'b0, a[NW-1:0]};
    assign b_lo  = {1'b0, b[NW-1:0]};
    assign cy_lo = {{NW{1'b0}}, cy};
    assign a_w   = {1'b0, a};
    assign b_w   = {1'b0, b};
    assign cy_w  = {{DW{1'b0}}, cy};

    always_comb begin
        lo   = '0;
        full = '0;
        res  = a;
        fout = fin;
        unique case (op)
            OP_ADD, OP_ADC: begin
                lo     = a_lo + b_lo + cy_lo;
                full   = a_w + b_w + cy_w;
                res    = full[DW-1:0];
                fout.z = (full[DW-1:0] == '0);
                fout.n = 1'b0;
                fout.h = lo[NW];
                fout.c = full[DW];
            end
            OP_SUB, OP_SBC, OP_CP: begin
                lo     = a_lo - b_lo - cy_lo;
                full   = a_w - b_w - cy_w;
                res    = (op == OP_CP) ? a : full[DW-1:0];
                fout.z = (full[DW-1:0] == '0);
                fout.n = 1'b1;
                fout.h = lo[NW];
                fout.c = full[DW];
            end
            OP_INC: begin
                lo     = b_lo + {{NW{1'b0}}, 1'b1};
                full   = b_w + {{DW{1'b0}}, 1'b1};
                res    = full[DW-1:0];
                fout.z = (full[DW-1:0] == '0);
                fout.n = 1'b0;
                fout.h = lo[NW];
            end
            OP_DEC: begin
                lo     = b_lo - {{NW{1'b0}}, 1'b1};
                full   = b_w - {{DW{1'b0}}, 1'b1};
                res    = full[DW-1:0];
                fout.z = (full[DW-1:0] == '0);
                fout.n = 1'b1;
                fout.h = lo[NW];
            end
            default: begin
                res  = a;
                fout = fin;
            end
        endcase
    end

    // Carry is preserved by the step operations; checked against the input flag.
    always_comb begin
        p_step_keeps_c_r5: assert (!((op == OP_INC) || (op == OP_DEC)) || (fout.c == fin.c))
            else $error("R5 step operation altered carry");
        p_sub_sets_n_r2: assert (!((op == OP_SUB) || (op == OP_SBC) || (op == OP_CP)) || fout.n)
            else $error("R2 subtract class left N clear");
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flags_t        fin,
    output logic [DW-1:0] res,
    output flags_t        fout
);
    always_comb begin
        res  = a;
        fout = fin;
        unique case (op)
            OP_AND: begin
                res  = a & b;
                fout = '{z: ((a & b) == '0), n: 1'b0, h: 1'b1, c: 1'b0};
            end
            OP_OR: begin
                res  = a | b;
                fout = '{z: ((a | b) == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_XOR: begin
                res  = a ^ b;
                fout = '{z: ((a ^ b) == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_CPL: begin
                res    = ~a;
                fout.n = 1'b1;
                fout.h = 1'b1;
            end
            default: begin
                res  = a;
                fout = fin;
            end
        endcase
    end

    always_comb begin
        p_bitwise_zero_r4: assert (!((op == OP_AND) || (op == OP_OR) || (op == OP_XOR))
                                   || (fout.z == (res == '0)))
            else $error("R4 zero flag disagrees with bitwise result");
        p_cpl_keeps_zc_r6: assert (!(op == OP_CPL) || ((fout.z == fin.z) && (fout.c == fin.c)))
            else $error("R6 complement changed Z or C");
    end
endmodule

// File: rtl/alu8_flagops.sv
module alu8_flagops
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  flags_t        fin,
    output logic [DW-1:0] res,
    output flags_t        fout
);
    logic          need_hi, need_lo;
    logic [DW-1:0] corr;

    always_comb begin
        if (fin.n) begin
            need_hi = fin.c;
            need_lo = fin.h;
        end else begin
            need_hi = fin.c || (a > BCD_MAX);
            need_lo = fin.h || (a[NW-1:0] > DIGIT_MAX);
        end
        corr = (need_hi ? DAA_HI_ADJ : '0) | (need_lo ? DAA_LO_ADJ : '0);
    end

    always_comb begin
        res  = a;
        fout = fin;
        unique case (op)
            OP_SCF: begin
                fout.n = 1'b0;
                fout.h = 1'b0;
                fout.c = 1'b1;
            end
            OP_CCF: begin
                fout.n = 1'b0;
                fout.h = 1'b0;
                fout.c = ~fin.c;
            end
            OP_DAA: begin
                res    = fin.n ? (a - corr) : (a + corr);
                fout.z = (res == '0);
                fout.h = 1'b0;
                fout.c = fin.n ? fin.c : (fin.c | need_hi);
            end
            default: begin
                res  = a;
                fout = fin;
            end
        endcase
    end

    always_comb begin
        p_carry_ops_r7: assert (!((op == OP_SCF) || (op == OP_CCF))
                                || (!fout.n && !fout.h && (fout.z == fin.z) && (res == a)))
            else $error("R7 carry operation disturbed N, H, Z or the result");
        p_daa_keeps_n_r8: assert (!(op == OP_DAA) || ((fout.n == fin.n) && !fout.h))
            else $error("R8 decimal adjust changed N or left H set");
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  acc_i,
    input  logic [DW-1:0]  opnd_i,
    input  logic           z_i,
    input  logic           n_i,
    input  logic           h_i,
    input  logic           c_i,
    output logic [DW-1:0]  res_o,
    output logic           res_we_o,
    output logic           z_o,
    output logic           n_o,
    output logic           h_o,
    output logic           c_o,
    output logic [DW-1:0]  flag_byte_o
);
    alu_op_e       op;
    flags_t        fin, f_ar, f_lg, f_fl, fsel;
    logic [DW-1:0] r_ar, r_lg, r_fl;

    assign op  = alu_op_e'(op_i);
    assign fin = '{z: z_i, n: n_i, h: h_i, c: c_i};

    alu8_arith u_arith (
        .op   (op),
        .a    (acc_i),
        .b    (opnd_i),
        .fin  (fin),
        .res  (r_ar),
        .fout (f_ar)
    );

    alu8_logic u_logic (
        .op   (op),
        .a    (acc_i),
        .b    (opnd_i),
        .fin  (fin),
        .res  (r_lg),
        .fout (f_lg)
    );

    alu8_flagops u_flagops (
        .op   (op),
        .a    (acc_i),
        .fin  (fin),
        .res  (r_fl),
        .fout (f_fl)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_INC, OP_DEC: begin
                res_o = r_ar;
                fsel  = f_ar;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                res_o = r_lg;
                fsel  = f_lg;
            end
            OP_SCF, OP_CCF, OP_DAA: begin
                res_o = r_fl;
                fsel  = f_fl;
            end
            OP_RSV14, OP_RSV15: begin
                res_o = acc_i;
                fsel  = fin;
            end
        endcase
    end

    always_comb begin
        unique case (op)
            OP_CP, OP_SCF, OP_CCF, OP_RSV14, OP_RSV15: res_we_o = 1'b0;
            default:                                   res_we_o = 1'b1;
        endcase
    end

    assign z_o         = fsel.z;
    assign n_o         = fsel.n;
    assign h_o         = fsel.h;
    assign c_o         = fsel.c;
    assign flag_byte_o = {fsel.z, fsel.n, fsel.h, fsel.c, {FLAG_PAD{1'b0}}};

    always_comb begin
        p_cp_no_write_r3: assert (!(op == OP_CP) || (!res_we_o && (res_o == acc_i)))
            else $error("R3 compare wrote a result");
        p_reserved_idle_r10: assert (!((op == OP_RSV14) || (op == OP_RSV15))
                                     || (!res_we_o && ({z_o, n_o, h_o, c_o} == {z_i, n_i, h_i, c_i})))
            else $error("R10 reserved code had an effect");
        p_flag_pad_r9: assert (flag_byte_o[FLAG_PAD-1:0] == '0)
            else $error("R9 low flag-byte bits not zero");
    end
endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic       clk = 1'b0;
    logic [3:0] op_i;
    logic [7:0] acc_i, opnd_i;
    logic       z_i, n_i, h_i, c_i;
    logic [7:0] res_o, flag_byte_o;
    logic       res_we_o, z_o, n_o, h_o, c_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut (
        .op_i        (op_i),
        .acc_i       (acc_i),
        .opnd_i      (opnd_i),
        .z_i         (z_i),
        .n_i         (n_i),
        .h_i         (h_i),
        .c_i         (c_i),
        .res_o       (res_o),
        .res_we_o    (res_we_o),
        .z_o         (z_o),
        .n_o         (n_o),
        .h_o         (h_o),
        .c_o         (c_o),
        .flag_byte_o (flag_byte_o)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:       return "R1";
            2, 3:       return "R2";
            4:          return "R3";
            5, 6, 7:    return "R4";
            8, 9:       return "R5";
            10:         return "R6";
            11, 12:     return "R7";
            13:         return "R8";
            default:    return "R10";
        endcase
    endfunction

    // Returns {we, res[7:0], z, n, h, c}
    function automatic logic [12:0] model(input int op, input int a, input int b,
                                          input bit zi, input bit ni, input bit hi, input bit ci);
        int r, t, hn, corr;
        bit we, z, n, h, c;
        we = 1'b1; z = zi; n = ni; h = hi; c = ci; r = a;
        case (op)
            0, 1: begin
                t  = a + b + ((op == 1) ? int'(ci) : 0);
                hn = (a % 16) + (b % 16) + ((op == 1) ? int'(ci) : 0);
                r = t % 256; z = (r == 0); n = 0; h = (hn > 15); c = (t > 255);
            end
            2, 3, 4: begin
                t  = a - b - ((op == 3) ? int'(ci) : 0);
                hn = (a % 16) - (b % 16) - ((op == 3) ? int'(ci) : 0);
                r = (t + 256) % 256; z = (r == 0); n = 1; h = (hn < 0); c = (t < 0);
                if (op == 4) begin r = a; we = 0; end
            end
            5: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
            6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
            7: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
            8: begin r = (b + 1) % 256; z = (r == 0); n = 0; h = ((b % 16) == 15); end
            9: begin r = (b + 255) % 256; z = (r == 0); n = 1; h = ((b % 16) == 0); end
            10: begin r = 255 - a; n = 1; h = 1; end
            11: begin we = 0; n = 0; h = 0; c = 1; end
            12: begin we = 0; n = 0; h = 0; c = !ci; end
            13: begin
                corr = 0;
                if (!ni) begin
                    if (ci || a > 153) begin corr += 96; c = 1; end
                    if (hi || (a % 16) > 9) corr += 6;
                    r = (a + corr) % 256;
                end else begin
                    if (ci) corr += 96;
                    if (hi) corr += 6;
                    r = (a - corr + 256) % 256;
                end
                z = (r == 0); h = 0;
            end
            default: begin we = 0; end
        endcase
        return {we, 8'(r), z, n, h, c};
    endfunction

    initial begin
        logic [12:0] exp_v, act_v;
        logic [7:0]  exp_fb;
        bit          bad;
        string       msg;
        op_i = '0; acc_i = '0; opnd_i = '0; {z_i, n_i, h_i, c_i} = '0;
        #2;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                bad = 1'b0;
                msg = "";
                for (int b = 0; b < 256; b++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b);
                        z_i = b[7]; n_i = b[6]; h_i = b[5]; c_i = ci[0];
                        #0.01;
                        exp_v  = model(op, a, b, b[7], b[6], b[5], ci[0]);
                        exp_fb = {exp_v[3:0], 4'h0};
                        act_v  = {res_we_o, res_o, z_o, n_o, h_o, c_o};
                        if (!bad && (act_v !== exp_v || flag_byte_o !== exp_fb)) begin
                            bad = 1'b1;
                            $sformat(msg, "FAIL %s/R9 op=%0d a=%02h b=%02h cin=%0d actual we,res,znhc=%h fbyte=%02h expected %h fbyte=%02h",
                                     req_of(op), op, a, b, ci, act_v, flag_byte_o, exp_v, exp_fb);
                        end
                    end
                end
                checks++;
                if (bad) begin
                    failures++;
                    $display("%s", msg);
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule